// File: doc/BRIEF.md
# Two-Field Greyscale LCD Scan Controller

This block drives a passive monochrome LCD panel that takes four pixels per pixel strobe. The image lives in an 8K-byte video RAM and is packed at two bits per pixel. The controller works on a fixed grid of 6-clock slots. In each slot it puts one address on the video RAM and captures the returned byte. From the fetched bytes it builds a 4-bit data group and emits the pixel strobe, the line latch, the frame latch and the drive polarity.

Four shades of grey come from showing each frame as two 1-bit fields. The polarity output inverts between the two fields. In one field the data bus carries the low bit of every pixel, and in the other it carries the high bit. Size and scroll values set four things: the number of 4-pixel groups per line, the number of lines per field, the start address of each line, and a sub-byte pixel shift.

A CPU access to the video RAM takes one clock of a slot. The read data on that clock is discarded, and the scan timing does not change. A restart pulse, issued when software writes its control register, puts the scan back at the top-left corner.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: A line is made of 6-clock slots. Slots 0 to N-1 are pixel slots and slot N is the latch slot, where N = x_size[7:2] and the two low bits of x_size are ignored. lcd_pclk is high for one clock, at clock offset 2 of every slot from 1 to N. With x_size = 0xA0 a line is 246 clocks long.
- R2: lcd_line_latch is high for exactly one clock, at offset 3 of the latch slot. It is never high together with lcd_pclk.
- R3: A field is y_size lines long, and a y_size of 0 means 256 lines. lcd_frame_latch is high for the whole of line 0 of every field.
- R4: lcd_polarity is 1 after reset. It inverts when each field begins, and this includes the first field after a restart. It stays constant within a field.
- R5: While lcd_polarity is 0, lcd_data[n] carries bit 2n of the shifted byte. While it is 1, lcd_data[n] carries bit 2n+1. Pixel n sits in bits 2n+1:2n.
- R6: The group strobed in slot g+1 of a line is the low byte of ({B[g+1], B[g]} >> 2*x_scroll[1:0]). B[i] is the video RAM byte at (S + x_scroll[7:2] + i) mod 8192, and S is the start address of the line.
- R7: S advances by 0x30 on each line, or by 0x60 when x_size > 0xC3. It is kept to 13 bits, and a result of 0x1FE0 becomes 0.
- R8: S for line 0 is (y_scroll * 0x30) mod 8192, and a result of 0x1FE0 becomes 0.
- R9: A restart pulse starts a 6-clock prefetch slot on the next clock. That slot has no pixel strobe and no line latch, and line 0 of a new field follows it.
- R10: A cpu_steal on any single clock of a slot does not change the displayed data or any output timing.
- R11: With disp_en low, lcd_data is 0 at every pixel strobe while all timing outputs keep running.
- R12: During reset, lcd_pclk, lcd_line_latch, lcd_frame_latch and lcd_data are 0 and lcd_polarity is 1.
- R13: vram_addr changes only on the first clock of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | One-clock pulse that restarts the scan at the top-left |
| disp_en | input | 1 | Display enable; when low, data outputs are forced to zero |
| x_size | input | 8 | Line width; bits 7:2 give the number of 4-pixel groups |
| y_size | input | 8 | Lines per field (0 means 256) |
| x_scroll | input | 8 | Bits 7:2 give the byte offset, bits 1:0 give the pixel shift |
| y_scroll | input | 8 | Field start, in rows of 0x30 bytes |
| cpu_steal | input | 1 | The CPU owns the video RAM on this clock |
| vram_addr | output | 13 | Video RAM read address |
| vram_rdata | input | 8 | Video RAM read data (asynchronous read) |
| lcd_data | output | 4 | Four pixel bits for the panel |
| lcd_pclk | output | 1 | Pixel group strobe |
| lcd_line_latch | output | 1 | Line latch strobe |
| lcd_frame_latch | output | 1 | High during the first line of a field |
| lcd_polarity | output | 1 | Drive polarity; also selects the bit plane |

## Verification
The pixel path runs against a video RAM whose contents are a hash of the address, so a group taken from a wrong byte, a wrong neighbour or a wrong plane shows up at once. The nominal 160x160 geometry runs through more than one full field, which exposes any miscount of the 246-clock line or the 160-line field. Directed settings cover three cases: the 0x60 stride with its 0x1FE0 wrap, a field start that lands exactly on 0x1FE0, and an x_size with non-zero low bits. Random sizes, scrolls and single stolen clocks at random slot offsets follow, together with restarts at arbitrary points in a line. During a stolen clock the RAM bus returns junk, so a design that keeps stolen data displays a visible error.

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          disp_en,
  input  logic [7:0]    x_size,
  input  logic [7:0]    y_size,
  input  logic [7:0]    x_scroll,
  input  logic [7:0]    y_scroll,
  input  logic          cpu_steal,
  output logic [AW-1:0] vram_addr,
  input  logic [DW-1:0] vram_rdata,
  output logic [3:0]    lcd_data,
  output logic          lcd_pclk,
  output logic          lcd_line_latch,
  output logic          lcd_frame_latch,
  output logic          lcd_polarity
);
  localparam logic [AW-1:0] WRAP_AT = AW'(13'h1FE0);
  localparam logic [AW-1:0] STEP_N  = AW'(8'h30);
  localparam logic [AW-1:0] STEP_W  = AW'(8'h60);

  logic [2:0]    ph;
  logic [5:0]    slot;
  logic [7:0]    ln;
  logic          pol, pre;
  logic [AW-1:0] base, addr_q, nxt;
  logic [DW-1:0] fb, old_q;
  logic [3:0]    dq, grp;

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] v);
    return (v == WRAP_AT) ? '0 : v;
  endfunction

  wire [5:0]    nsl      = x_size[7:2];
  wire          is_latch = slot >= nsl;
  wire          last_ln  = ln >= (y_size - 8'd1);
  wire [AW-1:0] stride   = (x_size > 8'hC3) ? STEP_W : STEP_N;
  wire [AW-1:0] fstart   = wrap(AW'({y_scroll, 5'b0}) + AW'({y_scroll, 4'b0}));
  wire [AW-1:0] nbase    = last_ln ? fstart : wrap(base + stride);
  wire [AW-1:0] xo       = AW'(x_scroll[7:2]);
  wire [DW-1:0] rd       = cpu_steal ? fb : vram_rdata;
  wire [15:0]   pair     = {rd, old_q} >> {x_scroll[1:0], 1'b0};

  always_comb begin
    for (int n = 0; n < 4; n++) grp[n] = pair[2*n + (pol ? 1 : 0)];
  end

  always_comb begin
    if (!is_latch) begin
      if (({1'b0, slot} + 7'd1) < {1'b0, nsl}) nxt = base + xo + AW'(slot) + AW'(2);
      else                                     nxt = nbase + xo;
    end else begin
      nxt = nbase + xo + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      ph     <= '0;
      slot   <= '1;
      ln     <= '1;
      pre    <= 1'b1;
      base   <= '0;
      addr_q <= fstart + xo;
      fb     <= '0;
      old_q  <= '0;
      dq     <= '0;
      if (!rst_n) pol <= 1'b1;
    end else begin
      fb <= rd;
      if (ph == 3'd5) begin
        ph     <= '0;
        old_q  <= rd;
        addr_q <= nxt;
        if (!is_latch) begin
          dq   <= disp_en ? grp : 4'd0;
          slot <= slot + 6'd1;
        end else begin
          slot <= '0;
          pre  <= 1'b0;
          base <= nbase;
          ln   <= last_ln ? 8'd0 : ln + 8'd1;
          if (last_ln) pol <= ~pol;
        end
      end else begin
        ph <= ph + 3'd1;
      end
    end
  end

  assign vram_addr       = addr_q;
  assign lcd_data        = dq;
  assign lcd_pclk        = (ph == 3'd2) && !pre && (slot != 6'd0) && (slot <= nsl);
  assign lcd_line_latch  = (ph == 3'd3) && !pre && is_latch;
  assign lcd_frame_latch = (ln == 8'd0);
  assign lcd_polarity    = pol;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lcd_pclk && lcd_line_latch)); // R2
  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_line_latch |=> !lcd_line_latch); // R2
  AST_POL_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lcd_polarity) |-> (lcd_frame_latch && ph == 3'd0)); // R4
  AST_DARK_DATA: assert property (@(posedge clk) disable iff (!rst_n || restart)
    (ph == 3'd5 && !is_latch && !disp_en) |=> (lcd_data == 4'd0)); // R11
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != 3'd0) |-> $stable(vram_addr)); // R13
  AST_PCLK_PHASE: assert property (@(posedge clk) disable iff (!rst_n || restart)
    lcd_pclk |=> (ph == 3'd3)); // R1
endmodule

// File: tb/test_lcd_scan_ctrl.sv
module test_lcd_scan_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, restart, disp_en, cpu_steal;
  logic [7:0]  x_size, y_size, x_scroll, y_scroll;
  logic [12:0] vram_addr;
  logic [7:0]  vram_rdata, junk;
  logic [3:0]  lcd_data;
  logic        lcd_pclk, lcd_line_latch, lcd_frame_latch, lcd_polarity;
  logic [15:0] seed_q;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_ctrl i_lcd_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .restart(restart), .disp_en(disp_en),
    .x_size(x_size), .y_size(y_size), .x_scroll(x_scroll), .y_scroll(y_scroll),
    .cpu_steal(cpu_steal), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
    .lcd_data(lcd_data), .lcd_pclk(lcd_pclk), .lcd_line_latch(lcd_line_latch),
    .lcd_frame_latch(lcd_frame_latch), .lcd_polarity(lcd_polarity));

  function automatic logic [7:0] memf(input logic [12:0] a, input logic [15:0] s);
    logic [15:0] t;
    t = {3'b0, a} * 16'd40503 + s;
    return t[15:8] ^ t[7:0] ^ {3'b0, a[12:8]};
  endfunction

  assign vram_rdata = cpu_steal ? junk : memf(vram_addr, seed_q);

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int wrapf(input int v);
    int m = v & 32'h1FFF;
    return (m == 32'h1FE0) ? 0 : m;
  endfunction

  function automatic int line_start(input int xs, input int ysc, input int lf);
    int b = wrapf(ysc * 32'h30);
    for (int i = 0; i < lf; i++) b = wrapf(b + ((xs > 32'hC3) ? 32'h60 : 32'h30));
    return b;
  endfunction

  function automatic int exp_group(input int b, input int xsc, input int g, input int plane);
    int a0 = b + (xsc >> 2) + g;
    logic [15:0] pr;
    int r = 0;
    pr = {memf(13'(a0 + 1), seed_q), memf(13'(a0), seed_q)};
    pr = pr >> (2 * (xsc & 3));
    for (int n = 0; n < 4; n++) if (pr[2*n + plane]) r |= (1 << n);
    return r;
  endfunction

  task automatic run_phase(input int xs, input int ys, input int xsc, input int ysc,
                           input bit en, input int nlines, input bit steal_on, input string tag);
    int n_s = xs >> 2;
    int len = 6 * (n_s + 1);
    int yl = (ys == 0) ? 256 : ys;
    int fpol = 0, lb = 0, stp = 7, prev_addr = 0, total, s, p, l, lf;
    @(negedge clk);
    x_size = 8'(xs); y_size = 8'(ys); x_scroll = 8'(xsc); y_scroll = 8'(ysc);
    disp_en = en; seed_q = 16'($urandom); restart = 1'b1; cpu_steal = 1'b0;
    @(negedge clk);
    restart = 1'b0;
    total = 6 + nlines * len;
    for (int c = 0; c < total; c++) begin
      if (c < 6) begin s = -1; p = c; l = -1; lf = -1; end
      else begin
        l = (c - 6) / len; s = ((c - 6) % len) / 6; p = (c - 6) % 6; lf = l % yl;
      end
      if (p == 0) stp = steal_on ? int'($urandom % 8) : 7;
      cpu_steal = (p == stp);
      junk = 8'($urandom);
      if (c == 0) fpol = lcd_polarity;
      if (p != 0) check(vram_addr == 13'(prev_addr), "R13", "address moved in slot", vram_addr, prev_addr);
      prev_addr = vram_addr;
      if (c < 6) begin
        check(!lcd_pclk && !lcd_line_latch, "R9", "strobe in prefetch slot", {lcd_pclk, lcd_line_latch}, 0);
      end else begin
        if (s == 0 && p == 0) begin
          lb = line_start(xs, ysc, lf);
          if (lf == 0) begin
            check(lcd_polarity != fpol[0], "R4", "polarity not inverted at field", lcd_polarity, !fpol[0]);
            fpol = lcd_polarity;
          end
        end
        if (p == 0) check(lcd_frame_latch == (lf == 0), "R3", "frame latch", lcd_frame_latch, lf == 0);
        check(lcd_pclk == (s >= 1 && p == 2), "R1", "pixel strobe", lcd_pclk, s >= 1 && p == 2);
        check(lcd_line_latch == (s == n_s && p == 3), "R2", "line latch", lcd_line_latch, s == n_s && p == 3);
        if (s >= 1 && p == 2) begin
          int e = en ? exp_group(lb, xsc, s - 1, fpol) : 0;
          check(lcd_polarity == fpol[0], "R4", "polarity changed in field", lcd_polarity, fpol);
          check(int'(lcd_data) == e, tag, "pixel group", lcd_data, e);
        end
      end
      @(negedge clk);
    end
    cpu_steal = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; restart = 1'b0; disp_en = 1'b1; cpu_steal = 1'b0; junk = '0; seed_q = '0;
    x_size = 8'hA0; y_size = 8'hA0; x_scroll = '0; y_scroll = '0;
    repeat (3) @(negedge clk);
    check(!lcd_pclk && !lcd_line_latch && !lcd_frame_latch, "R12", "strobes in reset",
          {lcd_pclk, lcd_line_latch, lcd_frame_latch}, 0);
    check(lcd_data == 4'd0, "R12", "data in reset", lcd_data, 0);
    check(lcd_polarity == 1'b1, "R12", "polarity in reset", lcd_polarity, 1);
    rst_n = 1'b1;
    run_phase(32'hA0, 32'hA0, 0, 0, 1'b1, 162, 1'b1, "R5");
    repeat (37) @(negedge clk);
    run_phase(32'hA3, 4, 32'h05, 32'h03, 1'b1, 9, 1'b0, "R6");
    repeat (101) @(negedge clk);
    run_phase(32'hC4, 7, 32'h8E, 32'hA0, 1'b1, 15, 1'b0, "R7");
    run_phase(32'hA0, 3, 32'h0B, 32'hAA, 1'b1, 7, 1'b0, "R8");
    run_phase(32'h40, 2, 32'h07, 32'hAB, 1'b1, 5, 1'b0, "R8");
    run_phase(32'h50, 3, 32'h12, 32'h01, 1'b0, 7, 1'b1, "R11");
    run_phase(32'hFF, 2, 32'h33, 32'h44, 1'b1, 5, 1'b1, "R10");
    for (int k = 0; k < 6; k++) begin
      int xs = 8 + int'($urandom % 248);
      int ys = 1 + int'($urandom % 5);
      repeat (int'($urandom % 300)) @(negedge clk);
      run_phase(xs, ys, int'($urandom % 256), int'($urandom % 256), 1'b1, 2 * ys + 1, 1'b1, "R6");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule